// File: doc/BRIEF.md
# Test Access Port with Multi-Device Identification Chain

This block is a serial test access port. A four-state-bit controller follows the standard sixteen-state test graph and is clocked on the rising edge of the test clock, with the mode-select input steering each transition. Behind the controller sit two scan paths. One is a 46-bit instruction path. The other is a 197-bit identification path that carries six 32-bit device codes in one long chain.

On every entry into the data-capture state, the identification path is cleared and reloaded from a set of codes. A two-bit hardware-revision input chooses which set. A host walks the controller into data-shift and clocks the chain out one bit per edge. It walks into instruction-shift to load a new instruction word, which becomes visible on a parallel output after instruction-update.

Every action is taken on the rising edge that enters the state the action belongs to. The serial output is registered on that same edge.

Top module: `jtag_idchain_tap`

## Requirements
- R1: While `trst_n` is low, the block is held in Test-Logic-Reset at once, without waiting for a clock edge. Both the instruction path and the identification chain are cleared, and `cur_instr` and `tdo` read 0.
- R2: State changes happen only on the rising edge of `tck` and follow the standard sixteen-state test graph under `tms`. Five consecutive edges with `tms` high reach Test-Logic-Reset from any state. Entering that state through `tms` leaves `cur_instr` unchanged.
- R3: On the edge that enters Capture-IR, the instruction path is loaded with the value 1: bits 1:0 become 01 and all higher bits become 0. The first two bits shifted out afterwards are therefore 1 and then 0.
- R4: On each edge that enters Shift-IR, `tdo` takes instruction bit 0, the path shifts toward bit 0, and `tdi` is written into bit 45. After 46 such edges, the path holds the 46 `tdi` values, with the first one in bit 0.
- R5: On the edge that enters Update-IR, the whole instruction path is copied to `cur_instr`. `cur_instr` changes on no other edge.
- R6: On the edge that enters Capture-DR, the whole chain is cleared and six codes are loaded at chain bits 1, 33, 65, 97, 130 and 162, with each code's most significant bit at its lowest chain bit. Chain bits 0, 129 and 194 to 196 therefore read 0.
- R7: On each edge that enters Shift-DR, `tdo` takes chain bit 196, every bit moves up by one position, and 0 enters bit 0. `tdi` has no effect on this path. As a result, three 0 bits come out first, followed by the sixth code least significant bit first.
- R8: `rev_sel` is sampled at Capture-DR. Code 0 loads 116C7057, 216C3057, 116C4057, 216C5057, 116C6057, 116C6057. Code 1 loads 316C7057, 316C3057, 216C4057, 316C5057, 216C6057, 216C6057. Codes 2 and 3 load 416C7057, 416C3057, 316C4057, 416C5057, 316C6057, 316C6057. The codes are listed from chain offset 1 upward.
- R9: `tdo` changes only on edges that enter Shift-DR or Shift-IR.
- R10: After 197 Shift-DR edges with no new capture, every further Shift-DR edge presents 0 on `tdo`.
- R11: The pause and exit states hold both scan paths unchanged. A shift resumed from Exit2 continues with the next bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; the block acts on its rising edge |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data in, used by the instruction path only |
| rev_sel | input | 2 | Hardware-revision code that selects the ID set |
| tdo | output | 1 | Registered serial data out |
| cur_instr | output | 46 | Instruction latched at the last Update-IR |

## Verification
A wrong controller state shows at the ports within a few edges. A missed transition either skips a capture, so `tdo` repeats old chain data, or inserts an unexpected shift that moves `tdo` one bit early. Both are caught on the next compared edge. A wrong chain layout or code table stays hidden until the affected bit reaches position 196, which can take up to 197 shift edges. For that reason, every scan clocks the full chain out and rebuilds each code from the serial stream. A corrupted instruction path shows in `cur_instr` one edge after Update-IR, and its capture pattern shows in the first two instruction-shift bits.

// File: rtl/jtag_idc_pkg.sv
package jtag_idc_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EX1, ST_DR_PAUSE, ST_DR_EX2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1, ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD
  } tap_st_e;

  // Controller graph: successor of s for mode-select value m
  function automatic tap_st_e tap_next(tap_st_e s, logic m);
    tap_st_e n;
    case (s)
      ST_RESET:    n = m ? ST_RESET    : ST_IDLE;
      ST_IDLE:     n = m ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   n = m ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   n = m ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_SHIFT: n = m ? ST_DR_EX1   : ST_DR_SHIFT;
      ST_DR_EX1:   n = m ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: n = m ? ST_DR_EX2   : ST_DR_PAUSE;
      ST_DR_EX2:   n = m ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   n = m ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   n = m ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   n = m ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_SHIFT: n = m ? ST_IR_EX1   : ST_IR_SHIFT;
      ST_IR_EX1:   n = m ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: n = m ? ST_IR_EX2   : ST_IR_PAUSE;
      ST_IR_EX2:   n = m ? ST_IR_UPD   : ST_IR_SHIFT;
      default:     n = m ? ST_DR_SEL   : ST_IDLE;  // ST_IR_UPD
    endcase
    return n;
  endfunction

  // Device code for chain slot idx under revision rev.
  // Form: {generation nibble, 16C, device digit, 057}
  function automatic logic [31:0] id_code(logic [1:0] rev, int idx);
    logic [3:0] dig;
    logic [3:0] gen;
    logic       late;
    case (idx)
      0:       dig = 4'h7;
      1:       dig = 4'h3;
      2:       dig = 4'h4;
      3:       dig = 4'h5;
      default: dig = 4'h6;
    endcase
    late = (idx == 2) || (idx >= 4);
    case (rev)
      2'd0:    gen = (idx == 1 || idx == 3) ? 4'h2 : 4'h1;
      2'd1:    gen = late ? 4'h2 : 4'h3;
      default: gen = late ? 4'h3 : 4'h4;
    endcase
    return {gen, 12'h16C, dig, 12'h057};
  endfunction

  // Lowest chain bit of slot idx: one leading gap bit, one extra gap before slot gap_idx
  function automatic int id_offset(int idx, int id_w, int gap_idx);
    return 1 + idx * id_w + ((idx >= gap_idx) ? 1 : 0);
  endfunction

endpackage

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import jtag_idc_pkg::*;
(
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  output logic ev_cap_dr,
  output logic ev_shift_dr,
  output logic ev_cap_ir,
  output logic ev_shift_ir,
  output logic ev_upd_ir
);

  localparam int ONES_TO_RESET = 5;
  localparam int OW = $clog2(ONES_TO_RESET + 1);

  tap_st_e       state_q;
  tap_st_e       state_nxt;
  logic [OW-1:0] ones_q;

  assign state_nxt = tap_next(state_q, tms);

  // Actions belong to the state being entered on this edge
  assign ev_cap_dr   = (state_nxt == ST_DR_CAP);
  assign ev_shift_dr = (state_nxt == ST_DR_SHIFT);
  assign ev_cap_ir   = (state_nxt == ST_IR_CAP);
  assign ev_shift_ir = (state_nxt == ST_IR_SHIFT);
  assign ev_upd_ir   = (state_nxt == ST_IR_UPD);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= ST_RESET;
    else         state_q <= state_nxt;
  end

  // Run of consecutive tms-high edges, saturating (feeds the R2 check)
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                         ones_q <= '0;
    else if (!tms)                       ones_q <= '0;
    else if (ones_q != OW'(ONES_TO_RESET)) ones_q <= ones_q + 1'b1;
  end

  p_five_ones_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_q == OW'(ONES_TO_RESET)) |-> (state_q == ST_RESET));

  p_reset_exit_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (state_q == ST_RESET && !tms) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/tap_ir.sv
module tap_ir #(
  parameter int IR_LEN = 46
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tdi,
  input  logic              ev_cap,
  input  logic              ev_shift,
  input  logic              ev_upd,
  output logic              ir_lsb,
  output logic [IR_LEN-1:0] cur_instr
);

  localparam logic [IR_LEN-1:0] IR_CAPTURE = {{(IR_LEN-1){1'b0}}, 1'b1};

  logic [IR_LEN-1:0] ir_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       ir_q <= '0;
    else if (ev_cap)   ir_q <= IR_CAPTURE;
    else if (ev_shift) ir_q <= {tdi, ir_q[IR_LEN-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     cur_instr <= '0;
    else if (ev_upd) cur_instr <= ir_q;
  end

  assign ir_lsb = ir_q[0];

  p_ir_capture_r3: assert property (@(posedge tck) disable iff (!trst_n)
    ev_cap |=> (ir_lsb == 1'b1));

  p_instr_stable_r5: assert property (@(posedge tck) disable iff (!trst_n)
    !ev_upd |=> $stable(cur_instr));

  p_ir_hold_r11: assert property (@(posedge tck) disable iff (!trst_n)
    !(ev_cap || ev_shift) |=> $stable(ir_q));

endmodule

// File: rtl/tap_idchain.sv
module tap_idchain
  import jtag_idc_pkg::*;
#(
  parameter int CHAIN_LEN = 197,
  parameter int ID_W      = 32,
  parameter int N_ID      = 6,
  parameter int GAP_IDX   = 4
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic [1:0] rev_sel,
  input  logic       ev_cap,
  input  logic       ev_shift,
  output logic       chain_msb
);

  logic [ID_W-1:0]      id_words [N_ID];
  logic [CHAIN_LEN-1:0] cap_vec;
  logic [CHAIN_LEN-1:0] chain_q;

  for (genvar g = 0; g < N_ID; g++) begin : g_id
    assign id_words[g] = ID_W'(id_code(rev_sel, g));
  end

  // Clear everything, then place each code MSB-first from its offset upward
  always_comb begin
    cap_vec = '0;
    for (int i = 0; i < N_ID; i++) begin
      for (int j = 0; j < ID_W; j++) begin
        cap_vec[id_offset(i, ID_W, GAP_IDX) + j] = id_words[i][ID_W-1-j];
      end
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       chain_q <= '0;
    else if (ev_cap)   chain_q <= cap_vec;
    else if (ev_shift) chain_q <= {chain_q[CHAIN_LEN-2:0], 1'b0};
  end

  assign chain_msb = chain_q[CHAIN_LEN-1];

  p_lead_gap_r6: assert property (@(posedge tck) disable iff (!trst_n)
    ev_cap |=> (chain_q[0] == 1'b0));

  p_zero_fill_r7: assert property (@(posedge tck) disable iff (!trst_n)
    ev_shift |=> (chain_q[0] == 1'b0));

  p_chain_hold_r11: assert property (@(posedge tck) disable iff (!trst_n)
    !(ev_cap || ev_shift) |=> $stable(chain_q));

endmodule

// File: rtl/jtag_idchain_tap.sv
module jtag_idchain_tap #(
  parameter int IR_LEN    = 46,
  parameter int CHAIN_LEN = 197,
  parameter int ID_W      = 32,
  parameter int N_ID      = 6,
  parameter int GAP_IDX   = 4
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [1:0]        rev_sel,
  output logic              tdo,
  output logic [IR_LEN-1:0] cur_instr
);

  logic ev_cap_dr, ev_shift_dr, ev_cap_ir, ev_shift_ir, ev_upd_ir;
  logic ir_lsb, chain_msb;

  tap_ctrl u_ctrl (
    .tck         (tck),
    .trst_n      (trst_n),
    .tms         (tms),
    .ev_cap_dr   (ev_cap_dr),
    .ev_shift_dr (ev_shift_dr),
    .ev_cap_ir   (ev_cap_ir),
    .ev_shift_ir (ev_shift_ir),
    .ev_upd_ir   (ev_upd_ir)
  );

  tap_ir #(.IR_LEN(IR_LEN)) u_ir (
    .tck       (tck),
    .trst_n    (trst_n),
    .tdi       (tdi),
    .ev_cap    (ev_cap_ir),
    .ev_shift  (ev_shift_ir),
    .ev_upd    (ev_upd_ir),
    .ir_lsb    (ir_lsb),
    .cur_instr (cur_instr)
  );

  tap_idchain #(
    .CHAIN_LEN (CHAIN_LEN),
    .ID_W      (ID_W),
    .N_ID      (N_ID),
    .GAP_IDX   (GAP_IDX)
  ) u_chain (
    .tck       (tck),
    .trst_n    (trst_n),
    .rev_sel   (rev_sel),
    .ev_cap    (ev_cap_dr),
    .ev_shift  (ev_shift_dr),
    .chain_msb (chain_msb)
  );

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          tdo <= 1'b0;
    else if (ev_shift_ir) tdo <= ir_lsb;
    else if (ev_shift_dr) tdo <= chain_msb;
  end

  p_tdo_hold_r9: assert property (@(posedge tck) disable iff (!trst_n)
    !(ev_shift_dr || ev_shift_ir) |=> $stable(tdo));

  p_tdo_ir_r4: assert property (@(posedge tck) disable iff (!trst_n)
    ev_shift_ir |=> (tdo == $past(ir_lsb)));

  p_tdo_dr_r7: assert property (@(posedge tck) disable iff (!trst_n)
    ev_shift_dr |=> (tdo == $past(chain_msb)));

endmodule

// File: tb/sim_jtag_idchain_tap.sv
module sim_jtag_idchain_tap;

  localparam int IRL = 46;
  localparam int CL  = 197;

  // Reference state numbering of the bench's own
  localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_SHDR = 4, S_E1DR = 5,
                 S_PDR = 6, S_E2DR = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_SHIR = 11,
                 S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;

  logic           tck = 1'b0;
  logic           trst_n = 1'b0;
  logic           tms = 1'b1;
  logic           tdi = 1'b0;
  logic [1:0]     rev_sel = 2'd2;
  logic           tdo;
  logic [IRL-1:0] cur_instr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  jtag_idchain_tap u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .rev_sel(rev_sel), .tdo(tdo), .cur_instr(cur_instr)
  );

  always #2.5 tck = ~tck;   // 200 MHz

  // ---------------- reference model ----------------
  int             m_st;
  logic [IRL-1:0] m_ir;
  logic [IRL-1:0] m_cur;
  logic           m_tdo;
  bit             m_q[$];          // front = next bit to leave
  bit             outs[256];

  function automatic int ref_next(int s, logic m);
    case (s)
      S_TLR:  return m ? S_TLR : S_RTI;
      S_RTI:  return m ? S_SDR : S_RTI;
      S_SDR:  return m ? S_SIR : S_CDR;
      S_CDR, S_SHDR: return m ? S_E1DR : S_SHDR;
      S_E1DR: return m ? S_UDR : S_PDR;
      S_PDR:  return m ? S_E2DR : S_PDR;
      S_E2DR: return m ? S_UDR : S_SHDR;
      S_SIR:  return m ? S_TLR : S_CIR;
      S_CIR, S_SHIR: return m ? S_E1IR : S_SHIR;
      S_E1IR: return m ? S_UIR : S_PIR;
      S_PIR:  return m ? S_E2IR : S_PIR;
      S_E2IR: return m ? S_UIR : S_SHIR;
      default: return m ? S_SDR : S_RTI;   // both update states
    endcase
  endfunction

  function automatic logic [31:0] ref_id(logic [1:0] r, int k);
    logic [31:0] t0 [6] = '{32'h116C7057, 32'h216C3057, 32'h116C4057, 32'h216C5057, 32'h116C6057, 32'h116C6057};
    logic [31:0] t1 [6] = '{32'h316C7057, 32'h316C3057, 32'h216C4057, 32'h316C5057, 32'h216C6057, 32'h216C6057};
    logic [31:0] t2 [6] = '{32'h416C7057, 32'h416C3057, 32'h316C4057, 32'h416C5057, 32'h316C6057, 32'h316C6057};
    if (r == 2'd0) return t0[k];
    if (r == 2'd1) return t1[k];
    return t2[k];
  endfunction

  function automatic int ref_off(int k);
    int offs [6] = '{1, 33, 65, 97, 130, 162};
    return offs[k];
  endfunction

  task automatic model_reset();
    m_st = S_TLR; m_ir = '0; m_cur = '0; m_tdo = 1'b0;
    m_q.delete();
    for (int n = 0; n < CL; n++) m_q.push_back(1'b0);
  endtask

  task automatic model_edge(logic m, logic d);
    bit img[CL];
    m_st = ref_next(m_st, m);
    case (m_st)
      S_CDR: begin
        for (int n = 0; n < CL; n++) img[n] = 1'b0;
        for (int k = 0; k < 6; k++)
          for (int j = 0; j < 32; j++) img[ref_off(k) + j] = ref_id(rev_sel, k)[31-j];
        m_q.delete();
        for (int n = CL - 1; n >= 0; n--) m_q.push_back(img[n]);
      end
      S_SHDR: begin
        m_tdo = m_q.pop_front();
        m_q.push_back(1'b0);
      end
      S_CIR:  m_ir = IRL'(1);
      S_SHIR: begin
        m_tdo = m_ir[0];
        m_ir  = {d, m_ir[IRL-1:1]};
      end
      S_UIR:  m_cur = m_ir;
      default: ;
    endcase
  endtask

  // ---------------- checking ----------------
  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock: drive, edge, model, compare at the falling edge
  task automatic step(logic m, logic d, string tag);
    tms = m; tdi = d;
    @(posedge tck);
    model_edge(m, d);
    @(negedge tck);
    check({tag, " tdo"}, 64'(tdo), 64'(m_tdo));
    check({tag, " cur_instr"}, 64'(cur_instr), 64'(m_cur));
  endtask

  task automatic async_reset(string tag);
    #1 trst_n = 1'b0;
    model_reset();
    #0.5;
    check({tag, " tdo"}, 64'(tdo), 64'd0);
    check({tag, " cur_instr"}, 64'(cur_instr), 64'd0);
    @(negedge tck);
    trst_n = 1'b1;
  endtask

  // Full data scan from Run-Test/Idle; records nsh bits of tdo
  task automatic dr_scan(logic [1:0] rev, int nsh, string tag);
    rev_sel = rev;
    step(1'b1, 1'b0, "R2 sel-dr");
    step(1'b0, 1'b0, "R6 capture");
    for (int n = 0; n < nsh; n++) begin
      step(1'b0, n[0] ^ n[2], {tag, " R7 shift"});   // tdi toggles, must not matter
      outs[n] = tdo;
    end
    step(1'b1, 1'b0, "R9 exit1");
    step(1'b1, 1'b0, "R9 update");
    step(1'b0, 1'b0, "R2 idle");
  endtask

  task automatic check_ids(logic [1:0] rev, string tag);
    logic [31:0] got;
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 32; j++) got[31-j] = outs[CL - 1 - ref_off(k) - j];
      check($sformatf("%s R8 id slot %0d", tag, k), 64'(got), 64'(ref_id(rev, k)));
    end
    check({tag, " R6 gap bits"}, 64'({outs[0], outs[1], outs[2], outs[CL-1-129], outs[CL-1]}), 64'd0);
  endtask

  task automatic ir_scan(logic [IRL-1:0] v, string tag);
    step(1'b1, 1'b0, "R2 sel-dr");
    step(1'b1, 1'b0, "R2 sel-ir");
    step(1'b0, 1'b0, "R3 capture-ir");
    for (int k = 0; k < IRL; k++) begin
      step(1'b0, v[k], {tag, " R4 shift-ir"});
      if (k == 0) check("R3 first ir bit", 64'(tdo), 64'd1);
      if (k == 1) check("R3 second ir bit", 64'(tdo), 64'd0);
    end
    step(1'b1, 1'b0, "R5 exit1-ir");
    check("R5 no latch before update", 64'(cur_instr), 64'(m_cur));
    step(1'b1, 1'b0, "R5 update-ir");
    check({tag, " R5 latched"}, 64'(cur_instr), 64'(v));
    step(1'b0, 1'b0, "R2 idle");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge tck);
    check("R1 reset tdo", 64'(tdo), 64'd0);
    check("R1 reset cur_instr", 64'(cur_instr), 64'd0);
    trst_n = 1'b1;
    step(1'b1, 1'b0, "R2 hold tlr");
    step(1'b0, 1'b0, "R2 to idle");

    // Revision 2 IDs, plus extra shifts past the chain end
    dr_scan(2'd2, CL + 6, "rev2");
    check_ids(2'd2, "rev2");
    for (int n = CL; n < CL + 6; n++) check("R10 drained zero", 64'(outs[n]), 64'd0);

    dr_scan(2'd0, CL, "rev0");
    check_ids(2'd0, "rev0");
    dr_scan(2'd1, CL, "rev1");
    check_ids(2'd1, "rev1");
    dr_scan(2'd3, CL, "rev3");
    check_ids(2'd2, "rev3");

    // Instruction loads
    ir_scan(46'h2A5F_0C31_97E4, "ir a");
    ir_scan(46'h3FFF_FFFF_FFFF, "ir ones");

    // Pause in the middle of a data shift, then resume
    rev_sel = 2'd1;
    step(1'b1, 1'b0, "R2 sel-dr");
    step(1'b0, 1'b0, "R6 capture");
    for (int n = 0; n < 20; n++) step(1'b0, 1'b1, "R7 pre-pause");
    step(1'b1, 1'b0, "R11 exit1");
    for (int n = 0; n < 3; n++) step(1'b0, 1'b1, "R11 pause-dr");
    step(1'b1, 1'b0, "R11 exit2");
    for (int n = 0; n < 40; n++) step(1'b0, 1'b0, "R11 resumed");

    // Five tms-high edges from Shift-DR reach Test-Logic-Reset
    for (int n = 0; n < 5; n++) step(1'b1, 1'b0, "R2 tms reset");
    check("R2 instr kept", 64'(cur_instr), 64'h3FFF_FFFF_FFFF);
    step(1'b0, 1'b0, "R2 idle after tlr");

    // Pause in instruction shift
    step(1'b1, 1'b0, "R2 sel-dr");
    step(1'b1, 1'b0, "R2 sel-ir");
    step(1'b0, 1'b0, "R3 capture-ir");
    for (int n = 0; n < 10; n++) step(1'b0, n[0], "R4 shift-ir");
    step(1'b1, 1'b0, "R11 exit1-ir");
    step(1'b0, 1'b0, "R11 pause-ir");
    step(1'b1, 1'b0, "R11 exit2-ir");
    for (int n = 0; n < 36; n++) step(1'b0, n[1], "R4 resumed ir");
    step(1'b1, 1'b0, "R11 exit1-ir");
    step(1'b0, 1'b0, "R11 pause-ir");

    // Asynchronous reset mid-pause
    async_reset("R1 async");
    step(1'b0, 1'b0, "R1 idle after reset");
    dr_scan(2'd2, CL, "post-reset");
    check_ids(2'd2, "post-reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule